// File: doc/BRIEF.md
# Serial Converter Output Interface Model

This block is the digital side of a 10-bit serial-output converter, built so that it can stand in for a real converter inside a test fabric. The host drives an active-low select and a serial clock. The model brings both into its own system clock domain through synchronizer chains and works on the edges it finds there. The value to be "converted" comes in on a parallel sample port. The model stores that value at the moment select goes low and returns it as a framed serial stream on a tri-state data pad.

While select is low, the model counts serial clock edges from the select falling edge. It changes its output bit on each falling serial edge. It reports hold status from the select fall until the thirteenth rising serial edge. It releases the pad after the sixteenth falling edge, or earlier if select returns high. Raising select before the frame ends cancels the frame and puts the model back in track. The next frame then counts from zero.

The system clock must run at least eight times faster than the serial clock. Each pin change reaches the outputs within three system clock cycles.

Top module: `sadc_serial_model`

## Requirements
- R1: On a select falling edge, the pad output enable rises, hold status rises, and the pad drives 0 before any falling serial clock edge.
- R2: The sample word is stored on the select falling edge. Changes on the sample port after that edge do not alter the bits of the current frame.
- R3: After falling serial edge k (1 to 15), the pad carries frame bit k. Bits 0 to 2 are 0, bits 3 to 12 are sample bits 9 down to 0 (most significant first), and bits 13 to 15 are 0. The pad bit changes only on a falling serial edge or on a select fall.
- R4: Hold status stays high through the twelfth rising serial edge and falls on the thirteenth rising edge.
- R5: The output enable falls on the sixteenth falling serial edge and stays low for as long as select stays low.
- R6: A select rising edge in mid-frame drops the output enable and hold status. The next frame counts its edges from zero again.
- R7: While select is high, serial clock edges have no effect: the output enable and hold status stay low.
- R8: After reset, the output enable is low and hold status is low (track).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select from the host, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous, idles high |
| sample_in | input | DATA_W | Parallel word to be returned in the next frame |
| sdata_pad | output | 1 | Tri-state serial data pad |
| sdata_oe | output | 1 | Output enable of the pad, high while driven |
| hold_o | output | 1 | 1 in hold, 0 in track |

## Verification
The bench builds the model with its default parameters: 10 data bits, 3 leading zeros, a 16-edge frame, hold release on rising edge 13, and two synchronizer stages. Each serial half period lasts six system cycles, so every edge settles through the synchronizers before the bench samples the outputs. With these values the bench reaches every frame bit position and both the release edge and the tri-state edge. Random cancel points show that an interrupted frame restarts cleanly.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic {
        MODE_TRACK = 1'b0,
        MODE_HOLD  = 1'b1
    } sadc_mode_e;

    typedef struct packed {
        logic sel_fall;
        logic sel_rise;
        logic sck_fall;
        logic sck_rise;
    } sadc_evt_t;

    function automatic logic frame_bit_in_data(input int idx, input int lead, input int width);
        return (idx >= lead) && (idx < lead + width);
    endfunction

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
            last  <= RST_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], async_i};
            last  <= chain[STAGES-1];
        end
    end

    assign level_o = chain[STAGES-1];
    assign rise_o  = chain[STAGES-1] & ~last;
    assign fall_o  = ~chain[STAGES-1] & last;
endmodule

// File: rtl/sadc_frame_ctrl.sv
module sadc_frame_ctrl
    import sadc_pkg::*;
#(
    parameter int FRAME_LEN = 16,
    parameter int HOLD_RISE = 13,
    parameter int CNT_W     = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  sadc_evt_t        evt,
    output logic             capture_o,
    output logic             oe_o,
    output sadc_mode_e       mode_o,
    output logic [CNT_W-1:0] fall_cnt_o
);
    localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] LAST_RISE = CNT_W'(HOLD_RISE - 1);

    logic             active;
    logic [CNT_W-1:0] rise_cnt;

    always_ff @(posedge clk) begin
        if (rst || evt.sel_rise) begin
            active     <= 1'b0;
            oe_o       <= 1'b0;
            mode_o     <= MODE_TRACK;
            fall_cnt_o <= '0;
            rise_cnt   <= '0;
        end else if (evt.sel_fall) begin
            active     <= 1'b1;
            oe_o       <= 1'b1;
            mode_o     <= MODE_HOLD;
            fall_cnt_o <= '0;
            rise_cnt   <= '0;
        end else begin
            if (active && oe_o && evt.sck_fall) begin
                fall_cnt_o <= fall_cnt_o + 1'b1;
                if (fall_cnt_o == LAST_FALL)
                    oe_o <= 1'b0;
            end
            if (active && (mode_o == MODE_HOLD) && evt.sck_rise) begin
                rise_cnt <= rise_cnt + 1'b1;
                if (rise_cnt == LAST_RISE)
                    mode_o <= MODE_TRACK;
            end
        end
    end

    assign capture_o = evt.sel_fall;
endmodule

// File: rtl/sadc_shifter.sv
module sadc_shifter
    import sadc_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int LEAD   = 3,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic [CNT_W-1:0]  idx_i,
    output logic              bit_o
);
    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= '0;
        else if (capture_i)
            word_q <= sample_i;
    end

    always_comb begin
        int pos;
        pos   = DATA_W - 1 - (int'(idx_i) - LEAD);
        bit_o = 1'b0;
        if (frame_bit_in_data(int'(idx_i), LEAD, DATA_W))
            bit_o = word_q[pos];
    end
endmodule

// File: rtl/sadc_serial_model.sv
module sadc_serial_model
    import sadc_pkg::*;
#(
    parameter int DATA_W    = 10,
    parameter int LEAD      = 3,
    parameter int FRAME_LEN = 16,
    parameter int HOLD_RISE = 13,
    parameter int SYNC_N    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] sample_in,
    output logic              sdata_pad,
    output logic              sdata_oe,
    output logic              hold_o
);
    localparam int CNT_W = $clog2(FRAME_LEN + 1);

    sadc_evt_t        evt;
    logic             cs_lvl;
    logic             sck_lvl;
    logic             capture;
    sadc_mode_e       mode;
    logic [CNT_W-1:0] fall_cnt;
    logic             sdata_bit;

    sadc_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) i_cs_sync (
        .clk(clk), .rst(rst), .async_i(cs_n),
        .level_o(cs_lvl), .rise_o(evt.sel_rise), .fall_o(evt.sel_fall)
    );

    sadc_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) i_sck_sync (
        .clk(clk), .rst(rst), .async_i(sclk),
        .level_o(sck_lvl), .rise_o(evt.sck_rise), .fall_o(evt.sck_fall)
    );

    sadc_frame_ctrl #(.FRAME_LEN(FRAME_LEN), .HOLD_RISE(HOLD_RISE), .CNT_W(CNT_W)) i_ctrl (
        .clk(clk), .rst(rst), .evt(evt),
        .capture_o(capture), .oe_o(sdata_oe), .mode_o(mode), .fall_cnt_o(fall_cnt)
    );

    sadc_shifter #(.DATA_W(DATA_W), .LEAD(LEAD), .CNT_W(CNT_W)) i_shift (
        .clk(clk), .rst(rst), .capture_i(capture), .sample_i(sample_in),
        .idx_i(fall_cnt), .bit_o(sdata_bit)
    );

    assign hold_o    = (mode == MODE_HOLD);
    assign sdata_pad = sdata_oe ? sdata_bit : 1'bz;

    logic unused_lvl;
    assign unused_lvl = sck_lvl;
endmodule

// File: rtl/sadc_checker.sv
module sadc_checker (
    input logic clk,
    input logic rst,
    input logic cs_lvl,
    input logic sel_fall,
    input logic sel_rise,
    input logic sck_fall,
    input logic sck_rise,
    input logic oe,
    input logic hold,
    input logic dbit
);
    AST_SELECT_ENTERS_HOLD: assert property (@(posedge clk) disable iff (rst)
        sel_fall |=> (oe && hold && !dbit)); // R1

    AST_BIT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (oe && $past(oe) && !$past(sck_fall) && !$past(sel_fall)) |-> $stable(dbit)); // R3

    AST_TRACK_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        ($fell(hold) && !cs_lvl) |-> $past(sck_rise)); // R4

    AST_DESELECT_CANCELS: assert property (@(posedge clk) disable iff (rst)
        sel_rise |=> (!oe && !hold)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cs_lvl && $past(cs_lvl)) |-> (!oe && !hold)); // R7
endmodule

bind sadc_serial_model sadc_checker i_chk (
    .clk(clk), .rst(rst), .cs_lvl(cs_lvl),
    .sel_fall(evt.sel_fall), .sel_rise(evt.sel_rise),
    .sck_fall(evt.sck_fall), .sck_rise(evt.sck_rise),
    .oe(sdata_oe), .hold(hold_o), .dbit(sdata_bit)
);

// File: tb/test_sadc_serial_model.sv
module test_sadc_serial_model;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b1;
    logic [9:0] sample_in = '0;
    logic       sdata_pad;
    logic       sdata_oe;
    logic       hold_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    sadc_serial_model i_sadc_serial_model (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sample_in(sample_in),
        .sdata_pad(sdata_pad), .sdata_oe(sdata_oe), .hold_o(hold_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string req, input logic act, input logic exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_bit(input logic [9:0] w, input int k);
        if (k >= 3 && k <= 12) return w[12-k];
        return 1'b0;
    endfunction

    task automatic idle_clocks();
        for (int i = 0; i < 4; i++) begin
            sclk = ~sclk;
            step(HALF);
            chk(sdata_oe === 1'b0, "R7 oe", sdata_oe, 1'b0);
            chk(hold_o === 1'b0, "R7 hold", hold_o, 1'b0);
        end
        sclk = 1'b1;
        step(HALF);
    endtask

    // abort_k in 1..16 cancels the frame before falling edge abort_k; 0 runs it to completion
    task automatic run_frame(input logic [9:0] w, input int abort_k);
        logic stop;
        stop = 1'b0;
        sample_in = w;
        step(3);
        cs_n = 1'b0;
        step(HALF);
        chk(sdata_oe === 1'b1, "R1 oe", sdata_oe, 1'b1);
        chk(hold_o === 1'b1, "R1 hold", hold_o, 1'b1);
        chk(sdata_pad === 1'b0, "R1 first bit", sdata_pad, 1'b0);
        sample_in = ~w; // R2: later sample changes must not show up
        for (int k = 1; k <= 16; k++) begin
            if (!stop) begin
                if (k == abort_k) begin
                    cs_n = 1'b1;
                    step(HALF);
                    chk(sdata_oe === 1'b0, "R6 oe", sdata_oe, 1'b0);
                    chk(hold_o === 1'b0, "R6 hold", hold_o, 1'b0);
                    stop = 1'b1;
                end else begin
                    sclk = 1'b0;
                    step(HALF);
                    if (k < 16) begin
                        chk(sdata_oe === 1'b1, "R5 oe kept", sdata_oe, 1'b1);
                        chk(sdata_pad === exp_bit(w, k), "R3 R2 bit", sdata_pad, exp_bit(w, k));
                    end else begin
                        chk(sdata_oe === 1'b0, "R5 oe off", sdata_oe, 1'b0);
                    end
                    chk(hold_o === ((k - 1) < 13), "R4 hold after fall", hold_o, ((k - 1) < 13));
                    sclk = 1'b1;
                    step(HALF);
                    chk(hold_o === (k < 13), "R4 hold after rise", hold_o, (k < 13));
                    if (k == 16)
                        chk(sdata_oe === 1'b0, "R5 oe stays off", sdata_oe, 1'b0);
                end
            end
        end
        if (!stop) begin
            cs_n = 1'b1;
            step(HALF);
            chk(sdata_oe === 1'b0, "R6 oe end", sdata_oe, 1'b0);
        end
        step(HALF);
    endtask

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        step(4);
        rst = 1'b0;
        step(2);
        chk(sdata_oe === 1'b0, "R8 oe", sdata_oe, 1'b0);
        chk(hold_o === 1'b0, "R8 hold", hold_o, 1'b0);

        idle_clocks();
        run_frame(10'h3FF, 0);
        run_frame(10'h000, 0);
        run_frame(10'h2AA, 0);
        run_frame(10'h155, 9);   // cancel in mid-frame
        run_frame(10'h201, 0);   // R6: restart counts from zero
        run_frame(10'h0F0, 14);  // cancel after hold release
        run_frame(10'h3C3, 1);   // cancel before first falling edge
        idle_clocks();
        for (int i = 0; i < 12; i++) begin
            logic [9:0] w;
            int ab;
            w  = 10'($urandom);
            ab = (($urandom % 3) == 0) ? int'($urandom % 16) + 1 : 0;
            run_frame(w, ab);
        end
        idle_clocks();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule